// File: doc/BRIEF.md
# Test Data Register Set for a Boundary-Scan Port

This block holds the data-side registers that sit behind a serial boundary-scan test port on a memory device. There are three of them. The first is a single-stage bypass cell. The second is a 32-bit identity word. The third is a boundary chain whose length is a parameter. A separate controller supplies the TAP controller states: capture, shift and update. The instruction register supplies a decoded 3-bit instruction code. From these the block selects one register, captures into it, shifts it from the serial input toward the serial output, and presents bit 0 of the selected register on the serial output.

The boundary chain captures the sampled pin levels. Any cell marked in a placeholder mask always captures a logic 1. An update strobe copies the chain into a parallel latch, which stands in for the pin drivers. Two decode outputs tell the pad ring what to do: one says the drivers should take their values from that latch, the other says every output should float. The identity word is built from parameters: a presence bit, a vendor field, a two-bit data-width field and a revision nibble.

Top module: `tdr_set`

## Requirements
- R1: While `trstN` is low, `tdo` and `bsrDrive` are 0 and every data register is cleared.
- R2: Instruction codes are decoded as follows. 3'b000 is external drive and selects the boundary chain. 3'b001 is identity read and selects the identity word. 3'b010 is sample/preload and selects the boundary chain. 3'b011 is sample with outputs floated and selects the boundary chain. Every other code selects the bypass cell.
- R3: The bypass cell captures 0. During shift, the `tdi` level taken at a rising edge appears on `tdo` at the next falling edge.
- R4: On capture with the boundary chain selected, cell i takes `pinLevels[i]`. A cell whose bit is 1 in `PLACE_MASK` takes 1 whatever the pin level.
- R5: On capture with identity read selected, the identity register loads the constant identity word.
- R6: The identity word has this layout. Bit 0 is 1. Bits 11:1 hold `VENDOR_CODE`. Bits 13:12 are 2'b00 when `WIDE_CFG`=1 (36-bit part) and 2'b10 otherwise (18-bit part). Bits 27:14 are 0. Bits 31:28 hold `DIE_REV`.
- R7: Each shift moves the selected register one place toward bit 0, and `tdi` enters at the top bit. `tdo` is registered on the falling edge of `tck` from bit 0 of the selected register, so bit 0 appears first.
- R8: A cycle with neither capture nor shift leaves every data register unchanged.
- R9: Update with the boundary chain selected copies the chain into `bsrDrive`. Update under any other instruction leaves `bsrDrive` unchanged.
- R10: `extDriveSel` is 1 only under code 3'b000. `forceHiZ` is 1 only under code 3'b011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous active-low test reset |
| tdi | input | 1 | Serial data in |
| instrCode | input | 3 | Decoded current instruction |
| captureDr | input | 1 | Controller is in the capture state |
| shiftDr | input | 1 | Controller is in the shift state |
| updateDr | input | 1 | Controller is in the update state |
| pinLevels | input | BSR_LEN | Sampled pin levels |
| tdo | output | 1 | Serial data out, falling-edge registered |
| bsrDrive | output | BSR_LEN | Boundary update latch (pin driver stub) |
| extDriveSel | output | 1 | Pads take their values from `bsrDrive` |
| forceHiZ | output | 1 | All outputs float |

## Verification
The bench builds the block with a 12-cell chain. Its placeholder mask sets cells 0, 5 and 11, so a placeholder sits at each end of the chain and one sits in the middle. It also selects the 18-bit configuration and revision 4'hA, so the width field takes its nonzero code and the revision nibble is not all zeros. With these settings the full 32-bit identity word can be compared bit by bit. The bench also checks that placeholders read as 1 even when their pins are driven to 0, and it can shift an update pattern through the whole chain in a short run.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

  localparam int ID_W     = 32;
  localparam int VENDOR_W = 11;
  localparam int INSTR_W  = 3;

  localparam logic [INSTR_W-1:0] INS_EXTDRIVE = 3'b000;
  localparam logic [INSTR_W-1:0] INS_IDREAD   = 3'b001;
  localparam logic [INSTR_W-1:0] INS_SAMPLE   = 3'b010;
  localparam logic [INSTR_W-1:0] INS_SAMPLEZ  = 3'b011;

  typedef struct packed {
    logic selBypass;
    logic selId;
    logic selBsr;
    logic capture;
    logic shift;
    logic update;
  } tdr_strobe_t;

  function automatic logic [ID_W-1:0] makeIdWord(
    input logic [3:0]          rev,
    input logic                wide,
    input logic [VENDOR_W-1:0] vendor
  );
    logic [ID_W-1:0] w;
    w         = '0;
    w[0]      = 1'b1;
    w[11:1]   = vendor;
    w[13:12]  = wide ? 2'b00 : 2'b10;
    w[31:28]  = rev;
    return w;
  endfunction

endpackage

// File: rtl/tdr_ctrl.sv
module tdr_ctrl
  import tdr_pkg::*;
(
  input  logic [INSTR_W-1:0] instrCode,
  input  logic               captureDr,
  input  logic               shiftDr,
  input  logic               updateDr,
  output tdr_strobe_t        strobes,
  output logic               extDriveSel,
  output logic               forceHiZ
);

  logic selBypass;
  logic selId;
  logic selBsr;

  always_comb begin
    selBypass   = 1'b0;
    selId       = 1'b0;
    selBsr      = 1'b0;
    extDriveSel = 1'b0;
    forceHiZ    = 1'b0;
    case (instrCode)
      INS_EXTDRIVE: begin
        selBsr      = 1'b1;
        extDriveSel = 1'b1;
      end
      INS_IDREAD:  selId  = 1'b1;
      INS_SAMPLE:  selBsr = 1'b1;
      INS_SAMPLEZ: begin
        selBsr   = 1'b1;
        forceHiZ = 1'b1;
      end
      default:     selBypass = 1'b1;
    endcase
  end

  always_comb begin
    strobes.selBypass = selBypass;
    strobes.selId     = selId;
    strobes.selBsr    = selBsr;
    strobes.capture   = captureDr;
    strobes.shift     = shiftDr & ~captureDr;
    strobes.update    = updateDr;
  end

endmodule

// File: rtl/tdr_datapath.sv
module tdr_datapath
  import tdr_pkg::*;
#(
  parameter int                BSR_LEN    = 16,
  parameter logic [BSR_LEN-1:0] PLACE_MASK = '0,
  parameter logic [ID_W-1:0]   ID_WORD    = 32'h0000_0001
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic               tdi,
  input  tdr_strobe_t        strobes,
  input  logic [BSR_LEN-1:0] pinLevels,
  output logic               tdo,
  output logic [BSR_LEN-1:0] bsrDrive
);

  logic               bypassReg;
  logic [ID_W-1:0]    idReg;
  logic [BSR_LEN-1:0] bsrShift;
  logic [BSR_LEN-1:0] bsrCapVal;
  logic               serialBit;

  // Capture source per boundary cell: placeholder cells are tied to 1
  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    if (PLACE_MASK[i]) begin : g_place
      assign bsrCapVal[i] = 1'b1;
    end else begin : g_pin
      assign bsrCapVal[i] = pinLevels[i];
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      bypassReg <= 1'b0;
    end else if (strobes.selBypass) begin
      if (strobes.capture)    bypassReg <= 1'b0;
      else if (strobes.shift) bypassReg <= tdi;
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      idReg <= '0;
    end else if (strobes.selId) begin
      if (strobes.capture)    idReg <= ID_WORD;
      else if (strobes.shift) idReg <= {tdi, idReg[ID_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      bsrShift <= '0;
    end else if (strobes.selBsr) begin
      if (strobes.capture)    bsrShift <= bsrCapVal;
      else if (strobes.shift) bsrShift <= {tdi, bsrShift[BSR_LEN-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      bsrDrive <= '0;
    end else if (strobes.update && strobes.selBsr) begin
      bsrDrive <= bsrShift;
    end
  end

  always_comb begin
    serialBit = bypassReg;
    if (strobes.selId)  serialBit = idReg[0];
    if (strobes.selBsr) serialBit = bsrShift[0];
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) tdo <= 1'b0;
    else        tdo <= serialBit;
  end

  // R3: bypass cell holds 0 after a capture
  p_bypass_cap_r3: assert property (@(posedge tck) disable iff (!trstN)
    (strobes.capture && strobes.selBypass) |=> !bypassReg);

  // R4: placeholder cells read 1 after a capture
  p_placeholder_r4: assert property (@(posedge tck) disable iff (!trstN)
    (strobes.capture && strobes.selBsr) |=> ((bsrShift & PLACE_MASK) == PLACE_MASK));

  // R5: identity capture yields the constant word
  p_id_capture_r5: assert property (@(posedge tck) disable iff (!trstN)
    (strobes.capture && strobes.selId) |=> (idReg == ID_WORD));

  // R8: idle cycles leave the data registers alone
  p_hold_r8: assert property (@(posedge tck) disable iff (!trstN)
    (!strobes.capture && !strobes.shift) |=>
      ($stable(bsrShift) && $stable(idReg) && $stable(bypassReg)));

  // R9: latch only moves on a boundary update
  p_latch_hold_r9: assert property (@(posedge tck) disable iff (!trstN)
    !(strobes.update && strobes.selBsr) |=> $stable(bsrDrive));

endmodule

// File: rtl/tdr_set.sv
module tdr_set
  import tdr_pkg::*;
#(
  parameter int                 BSR_LEN     = 16,
  parameter logic [BSR_LEN-1:0] PLACE_MASK  = 16'h8001,
  parameter logic               WIDE_CFG    = 1'b1,
  parameter logic [3:0]         DIE_REV     = 4'h0,
  parameter logic [VENDOR_W-1:0] VENDOR_CODE = 11'h0D9
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic               tdi,
  input  logic [2:0]         instrCode,
  input  logic               captureDr,
  input  logic               shiftDr,
  input  logic               updateDr,
  input  logic [BSR_LEN-1:0] pinLevels,
  output logic               tdo,
  output logic [BSR_LEN-1:0] bsrDrive,
  output logic               extDriveSel,
  output logic               forceHiZ
);

  localparam logic [ID_W-1:0] ID_WORD = makeIdWord(DIE_REV, WIDE_CFG, VENDOR_CODE);

  tdr_strobe_t strobes;

  tdr_ctrl u_ctrl (
    .instrCode  (instrCode),
    .captureDr  (captureDr),
    .shiftDr    (shiftDr),
    .updateDr   (updateDr),
    .strobes    (strobes),
    .extDriveSel(extDriveSel),
    .forceHiZ   (forceHiZ)
  );

  tdr_datapath #(
    .BSR_LEN   (BSR_LEN),
    .PLACE_MASK(PLACE_MASK),
    .ID_WORD   (ID_WORD)
  ) u_dp (
    .tck      (tck),
    .trstN    (trstN),
    .tdi      (tdi),
    .strobes  (strobes),
    .pinLevels(pinLevels),
    .tdo      (tdo),
    .bsrDrive (bsrDrive)
  );

  // R2: exactly one register selected
  p_one_sel_r2: assert property (@(posedge tck) disable iff (!trstN)
    $countones({strobes.selBypass, strobes.selId, strobes.selBsr}) == 1);

  // R10: floating outputs only come with the boundary chain selected
  p_hiz_sel_r10: assert property (@(posedge tck) disable iff (!trstN)
    forceHiZ |-> (strobes.selBsr && !extDriveSel));

  // R3: bypass shift reaches tdo by the next rising edge
  p_bypass_path_r3: assert property (@(posedge tck) disable iff (!trstN)
    (shiftDr && !captureDr && strobes.selBypass) |=> (tdo == $past(tdi)));

endmodule

// File: tb/tdr_set_tb_top.sv
`timescale 1ns/100ps
module tdr_set_tb_top;

  localparam int          LEN   = 12;
  localparam logic [11:0] MASK  = 12'b1000_0010_0001;
  localparam logic [3:0]  REV   = 4'hA;
  localparam logic [10:0] VEND  = 11'h0D9;

  logic            tck = 1'b0;
  logic            trstN = 1'b0;
  logic            tdi = 1'b0;
  logic [2:0]      instrCode = 3'b111;
  logic            captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0;
  logic [LEN-1:0]  pinLevels = '0;
  logic            tdo;
  logic [LEN-1:0]  bsrDrive;
  logic            extDriveSel, forceHiZ;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    bit    chk;
    logic  expV;
    string tag;
  } item_t;
  item_t q[$];

  always #2.5 tck = ~tck;

  tdr_set #(
    .BSR_LEN(LEN), .PLACE_MASK(MASK), .WIDE_CFG(1'b0),
    .DIE_REV(REV), .VENDOR_CODE(VEND)
  ) dut_i (
    .tck(tck), .trstN(trstN), .tdi(tdi), .instrCode(instrCode),
    .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr),
    .pinLevels(pinLevels), .tdo(tdo), .bsrDrive(bsrDrive),
    .extDriveSel(extDriveSel), .forceHiZ(forceHiZ)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of controls and queue the tdo expectation
  task automatic step(input logic [2:0] ins, input logic cap, input logic sh,
                      input logic upd, input logic din, input bit chk,
                      input logic expV, input string tag);
    item_t it;
    @(posedge tck); #1;
    instrCode = ins; captureDr = cap; shiftDr = sh; updateDr = upd; tdi = din;
    it.chk = chk; it.expV = expV; it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: the item queued two pushes back matches current tdo
  initial begin
    forever begin
      @(posedge tck); #0.5;
      if (q.size() >= 2) begin
        item_t it;
        it = q.pop_front();
        if (it.chk) check(it.tag, {31'b0, tdo}, {31'b0, it.expV});
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0]    idExp;
    logic [LEN-1:0] capExp;
    logic [LEN-1:0] pat;
    idExp = {REV, 14'b0, 2'b10, VEND, 1'b1};

    repeat (3) @(posedge tck);
    #1;
    check("R1 tdo in reset", {31'b0, tdo}, 32'd0);
    check("R1 bsrDrive in reset", {20'b0, bsrDrive}, 32'd0);
    @(posedge tck); #1; trstN = 1'b1;

    // Identity word: capture, then 31 shifts give bits 1..31 (R5, R6, R7)
    step(3'b001, 1, 0, 0, 0, 1, idExp[0], "R6 id bit0 presence");
    for (int j = 1; j < 32; j++)
      step(3'b001, 0, 1, 0, (j % 3 == 0), 1, idExp[j], "R5/R6 id bit");
    // Continue shifting: tdi bits from shift 1.. come back out (R7)
    for (int j = 32; j < 64; j++)
      step(3'b001, 0, 1, 0, 0, 1, ((j - 31) % 3 == 0), "R7 id shift-through");

    // Bypass with a default code and an unknown code (R2, R3)
    step(3'b111, 1, 0, 0, 1, 1, 1'b0, "R3 bypass capture 0");
    for (int j = 0; j < 6; j++)
      step(3'b111, 0, 1, 0, j[0], 1, j[0], "R3 bypass delay");
    step(3'b101, 1, 0, 0, 1, 1, 1'b0, "R2 unknown code bypass capture");
    for (int j = 0; j < 4; j++)
      step(3'b101, 0, 1, 0, ~j[1], 1, ~j[1], "R2 unknown code bypass shift");

    // Boundary capture under sample/preload (R4, R7, R8)
    pinLevels = 12'b0101_1010_0110;
    for (int i = 0; i < LEN; i++) capExp[i] = MASK[i] ? 1'b1 : pinLevels[i];
    step(3'b010, 1, 0, 0, 0, 1, capExp[0], "R4 bsr capture bit");
    for (int j = 1; j < 5; j++)
      step(3'b010, 0, 1, 0, 0, 1, capExp[j], "R4 bsr capture bit");
    for (int j = 0; j < 3; j++)
      step(3'b010, 0, 0, 0, 1, 1, capExp[4], "R8 hold while idle");
    for (int j = 5; j < LEN; j++)
      step(3'b010, 0, 1, 0, 0, 1, capExp[j], "R4 bsr capture bit");

    // Pins all low: placeholders still 1, outputs floated (R4, R10)
    pinLevels = '0;
    step(3'b011, 1, 0, 0, 0, 1, MASK[0], "R4 placeholder bit");
    #0.1;
    check("R10 forceHiZ under sample-z", {30'b0, forceHiZ, extDriveSel}, 32'b10);
    for (int j = 1; j < LEN; j++)
      step(3'b011, 0, 1, 0, 0, 1, MASK[j], "R4 placeholder bit");

    // Update under external drive (R9, R10)
    pat = 12'b1100_1010_0011;
    step(3'b000, 1, 0, 0, 0, 0, 1'b0, "");
    #0.1;
    check("R10 extDriveSel under ext drive", {30'b0, forceHiZ, extDriveSel}, 32'b01);
    for (int j = 0; j < LEN; j++)
      step(3'b000, 0, 1, 0, pat[j], 0, 1'b0, "");
    step(3'b000, 0, 0, 1, 0, 0, 1'b0, "");
    step(3'b000, 0, 0, 0, 0, 0, 1'b0, "");
    check("R9 update copies chain", {20'b0, bsrDrive}, {20'b0, pat});

    // Update with bypass selected leaves the latch (R9, R10)
    step(3'b110, 1, 0, 0, 0, 0, 1'b0, "");
    #0.1;
    check("R10 no pad control under bypass", {30'b0, forceHiZ, extDriveSel}, 32'b00);
    step(3'b110, 0, 1, 0, 1, 0, 1'b0, "");
    step(3'b110, 0, 0, 1, 0, 0, 1'b0, "");
    step(3'b110, 0, 0, 0, 0, 0, 1'b0, "");
    check("R9 latch unchanged off-chain", {20'b0, bsrDrive}, {20'b0, pat});

    step(3'b111, 0, 0, 0, 0, 0, 1'b0, "");
    step(3'b111, 0, 0, 0, 0, 0, 1'b0, "");
    step(3'b111, 0, 0, 0, 0, 0, 1'b0, "");
    finish_run();
  end

endmodule